// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block handles read misses for a direct-mapped data cache whose lines are several words wide. On a miss it sends one request to a slower backing memory, naming the exact word the processor wants. The memory returns the whole line one word per beat, starting with that word and wrapping around the line. Each beat is written into the data array at offset `(critical offset + beat number) mod words-per-line`.

The processor's stall ends on the very beat that carries its word. That word is forwarded straight from the memory port to the response port. The rest of the line keeps filling in the background. While the fill runs, further accesses to the same line complete once their word has arrived. Accesses to any other line wait until the fill is over. The tag and valid bit of the set are written together with the last word of the line, so a line that is only partly filled can never hit through the tag path.

The processor side is a request held high until a same-cycle acknowledge. Hits in the idle state are acknowledged combinationally, and read data is valid while the acknowledge is high. Addresses are word addresses split as `{tag, index, offset}`.

Top module: `cwf_refill_cache`

## Requirements
- R1: A miss raises `mem_req_o` for exactly one cycle, with `mem_addr_o` equal to the requested word address. With a memory latency of 4 cycles, the acknowledge arrives exactly 5 cycles after the request is raised, whatever the word offset.
- R2: Beat k of a fill is stored at word offset (critical offset + k) mod 8 of the line. After the fill, every word of the line reads back the memory's value for that address.
- R3: While a fill is running, the acknowledge and the forwarded data from `mem_data_i` appear in the same cycle as the beat that carries the requested word.
- R4: During a fill, an access to the filling line is acknowledged at once if its word has already been written. Otherwise it waits until the beat carrying that word.
- R5: During a fill, an access to any other line is not acknowledged until the fill has completed. This includes the line that is being evicted from the same set.
- R6: The tag and valid bit are written only with the last beat of a line. From the next cycle on, accesses to that line hit.
- R7: A hit while idle is acknowledged in the cycle of the request, with no wait and no memory request.
- R8: After reset no line is valid, and `mem_req_o` and `cpu_ack_o` are low while no request is made.
- R9: No new memory request is issued while a fill is running. A fill ends after exactly 8 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor read request, held until acknowledged |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_ack_o | output | 1 | Request completed this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid while `cpu_ack_o` is high |
| mem_req_o | output | 1 | One-cycle memory line request |
| mem_addr_o | output | ADDR_W | Critical word address of the request |
| mem_valid_i | input | 1 | Memory beat valid |
| mem_data_i | input | DATA_W | Memory beat data |

## Verification
The hardest situation to reach from the ports is an access that arrives while a fill is only partly done. It may target a word of the filling line that has not arrived yet, a word that has already arrived, or the set's old line whose tag is still present. The stimulus table chains its accesses back to back, so each one starts at a known beat of the ongoing fill: its expected wait is derived from the wrap order and the 4-cycle memory latency. One fill of a conflicting line is then interrupted by a request for the line being evicted.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cwf_store.sv
module cwf_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 3,
  parameter int TAG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tag_we_i,
  input  logic [TAG_W-1:0]  wr_tag_i
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [DATA_W-1:0] data_q [SETS*WORDS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [SETS-1:0]   valid_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[{wr_idx_i, wr_off_i}] <= wr_data_i;
    if (tag_we_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (tag_we_i) valid_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o  = data_q[{rd_idx_i, rd_off_i}];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];

  // tag install always comes with the final data word
  a_r6_tag_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_i |-> wr_en_i);
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic                    beat_valid_i,
  output logic                    busy_o,
  output logic [ADDR_W-OFF_W-1:0] line_o,
  output logic [OFF_W-1:0]        wr_off_o,
  output logic                    last_o,
  output logic [(1<<OFF_W)-1:0]   arrived_o
);
  import cwf_pkg::*;
  localparam int WORDS = 1 << OFF_W;

  fill_state_e             state_q;
  logic [ADDR_W-OFF_W-1:0] line_q;
  logic [OFF_W-1:0]        crit_q;
  logic [OFF_W-1:0]        beat_q;
  logic [WORDS-1:0]        arrived_q;

  assign busy_o    = (state_q == FILL_BUSY);
  assign line_o    = line_q;
  assign wr_off_o  = crit_q + beat_q;  // wraps mod WORDS
  assign last_o    = (beat_q == OFF_W'(WORDS-1));
  assign arrived_o = arrived_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FILL_IDLE;
      line_q    <= '0;
      crit_q    <= '0;
      beat_q    <= '0;
      arrived_q <= '0;
    end else begin
      unique case (state_q)
        FILL_IDLE: if (start_i) begin
          state_q   <= FILL_BUSY;
          line_q    <= start_addr_i[ADDR_W-1:OFF_W];
          crit_q    <= start_addr_i[OFF_W-1:0];
          beat_q    <= '0;
          arrived_q <= '0;
        end
        FILL_BUSY: if (beat_valid_i) begin
          arrived_q[wr_off_o] <= 1'b1;
          beat_q              <= beat_q + OFF_W'(1);
          if (last_o) state_q <= FILL_IDLE;
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  a_r2_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_valid_i && !last_o) |=> (busy_o && beat_q == $past(beat_q) + OFF_W'(1)));
  a_r9_fill_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_valid_i && last_o) |=> !busy_o);
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/cwf_refill_cache.sv
module cwf_refill_cache #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int WORDS  = 1 << OFF_W;

  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [LINE_W-1:0] req_line;

  assign req_off  = cpu_addr_i[OFF_W-1:0];
  assign req_idx  = cpu_addr_i[OFF_W +: IDX_W];
  assign req_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign req_line = cpu_addr_i[ADDR_W-1:OFF_W];

  logic              busy;
  logic [LINE_W-1:0] fill_line;
  logic [OFF_W-1:0]  fill_off;
  logic              fill_last;
  logic [WORDS-1:0]  arrived;
  logic              start;

  logic [DATA_W-1:0] rd_data;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid;
  logic              wr_en, tag_we;

  logic idle_hit, same_line, fwd_hit, arr_hit;

  assign idle_hit  = !busy && rd_valid && (rd_tag == req_tag);
  assign same_line = busy && (req_line == fill_line);
  assign fwd_hit   = same_line && mem_valid_i && (fill_off == req_off);
  assign arr_hit   = same_line && arrived[req_off];

  assign cpu_ack_o   = cpu_req_i && (idle_hit || arr_hit || fwd_hit);
  assign cpu_rdata_o = fwd_hit ? mem_data_i : rd_data;

  assign start      = cpu_req_i && !busy && !idle_hit;
  assign mem_req_o  = start;
  assign mem_addr_o = cpu_addr_i;

  assign wr_en  = busy && mem_valid_i;
  assign tag_we = wr_en && fill_last;

  cwf_fill_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_addr_i(cpu_addr_i),
    .beat_valid_i(mem_valid_i),
    .busy_o      (busy),
    .line_o      (fill_line),
    .wr_off_o    (fill_off),
    .last_o      (fill_last),
    .arrived_o   (arrived)
  );

  cwf_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (req_idx),
    .rd_off_i  (req_off),
    .rd_data_o (rd_data),
    .rd_tag_o  (rd_tag),
    .rd_valid_o(rd_valid),
    .wr_en_i   (wr_en),
    .wr_idx_i  (fill_line[IDX_W-1:0]),
    .wr_off_i  (fill_off),
    .wr_data_i (mem_data_i),
    .tag_we_i  (tag_we),
    .wr_tag_i  (fill_line[LINE_W-1 -: TAG_W])
  );

  a_r3_early_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && busy && req_line == fill_line && mem_valid_i && fill_off == req_off)
      |-> (cpu_ack_o && cpu_rdata_o == mem_data_i));
  a_r4_no_early_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cpu_ack_o) |-> (arrived[req_off] || mem_valid_i));
  a_r5_other_line_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cpu_req_i && req_line != fill_line) |-> !cpu_ack_o);
  a_r6_tag_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we |-> ($countones(arrived) == WORDS - 1));
  a_r7_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> cpu_req_i);
  a_r1_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
endmodule

// File: tb/sim_cwf_refill_cache.sv
module sim_cwf_refill_cache;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int MEM_LAT = 4;
  localparam int NVEC    = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic              cpu_ack;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_valid;
  logic [DATA_W-1:0] mem_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cwf_refill_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {20'hC0FFE ^ 20'(a), a};
  endfunction

  // backing memory: fixed latency, then 8 beats in wrap order
  logic              m_busy;
  int                m_wait;
  logic [2:0]        m_beat;
  logic [ADDR_W-1:0] m_base;
  int                req_cnt;
  logic [ADDR_W-1:0] last_req_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_wait <= 0; m_beat <= '0; m_base <= '0;
      mem_valid <= 1'b0; mem_data <= '0; req_cnt <= 0; last_req_addr <= '0;
    end else begin
      mem_valid <= 1'b0;
      if (mem_req) begin
        m_busy <= 1'b1; m_wait <= MEM_LAT - 1; m_beat <= '0; m_base <= mem_addr;
        req_cnt <= req_cnt + 1; last_req_addr <= mem_addr;
      end else if (m_busy) begin
        if (m_wait != 0) m_wait <= m_wait - 1;
        else begin
          mem_valid <= 1'b1;
          mem_data  <= mem_word({m_base[ADDR_W-1:3], 3'(m_base[2:0] + m_beat)});
          m_beat    <= m_beat + 3'd1;
          if (m_beat == 3'd7) m_busy <= 1'b0;
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a negedge, sample 2 ns later, count stalled cycles
  task automatic access(input logic [ADDR_W-1:0] a, output int waited, output logic [DATA_W-1:0] d);
    cpu_req = 1'b1; cpu_addr = a; waited = 0;
    forever begin
      #2;
      if (cpu_ack) begin d = cpu_rdata; break; end
      @(negedge clk); waited++;
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // addresses {tag, idx, off}: line A = tag 2 idx 1 (0x108), line B = tag 3 idx 1 (0x188)
  localparam logic [ADDR_W-1:0] V_ADDR [NVEC] = '{
    12'h10D, 12'h10D, 12'h108, 12'h10C, 12'h10A, 12'h188, 12'h10E, 12'h18B };
  localparam int V_WAIT [NVEC] = '{ 5, 0, 1, 3, 0, 5, 12, 12 };
  localparam bit V_MISS [NVEC] = '{ 1, 0, 0, 0, 0, 1, 1, 1 };
  localparam string V_REQ [NVEC] = '{
    "R1", "R4", "R4", "R4", "R6", "R1", "R5", "R5" };

  initial begin
    int w;
    logic [DATA_W-1:0] d;
    int rc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R8 ack idle", 64'(cpu_ack), 64'd0);
    check("R8 mem_req idle", 64'(mem_req), 64'd0);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      rc0 = req_cnt;
      access(V_ADDR[i], w, d);
      check(V_REQ[i], 64'(w), 64'(V_WAIT[i]));
      check("R2 data", 64'(d), 64'(mem_word(V_ADDR[i])));
      check("R9 req count", 64'(req_cnt - rc0), 64'(V_MISS[i]));
      if (V_MISS[i]) check("R1 crit addr", 64'(last_req_addr), 64'(V_ADDR[i]));
    end

    // vector 0: R3 forward on critical beat; vector 4: R7 idle hit zero wait
    repeat (12) @(negedge clk);
    rc0 = req_cnt;
    for (int k = 0; k < 8; k++) begin
      access(12'h188 + 12'(k), w, d);
      check("R7 hit wait", 64'(w), 64'd0);
      check("R2 wrap fill word", 64'(d), 64'(mem_word(12'h188 + 12'(k))));
    end
    check("R6 no refetch", 64'(req_cnt - rc0), 64'd0);

    // R3: miss at offset 7 acknowledges on first beat
    access(12'h237, w, d);
    check("R3 early restart wait", 64'(w), 64'(MEM_LAT + 1));
    check("R3 forwarded data", 64'(d), 64'(mem_word(12'h237)));

    repeat (12) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule